// File: doc/BRIEF.md
# CAN Transmit Request Control

This block holds one transmit request flag per message buffer of a CAN controller and hands pending frames, one at a time, to a CAN protocol engine. Software raises a request by writing a 1 into that buffer's position. Zeros in the written word leave the other flags as they were. The block offers the lowest-numbered pending buffer to the engine with a one-cycle start pulse. It then waits for the engine's done pulse, which carries a success or error flag.

Only a successful result retires a request. After an error the flag stays set, so the same frame is offered again. While the controller's initialization input is high, every request is wiped and writes are ignored. A frame that the engine has already taken is allowed to finish. If that frame fails, it is not offered again.

A per-buffer busy flag tells software when a buffer's data must not be touched. A buffer is busy while its request is set or while its frame is on the bus.

The sequencer has three states:
- `ST_IDLE`: no frame is with the engine. Transition *launch* goes to `ST_WAIT` when a request is pending and init is low.
- `ST_WAIT`: a frame is with the engine. Transition *finish* returns to `ST_IDLE` on done. Transition *abort* goes to `ST_ABORT` when init rises before done.
- `ST_ABORT`: the frame is finishing under init. Transition *drain* returns to `ST_IDLE` on done, with no retry.

Top module: `txreq_ctrl`

## Requirements
- R1: After reset all request flags and busy flags read 0, no start pulse is issued, and the sequencer is in `ST_IDLE`.
- R2: A write with `wr_en_i` high sets request flag i for every bit i of `wr_data_i` that is 1. A bit that is 0 leaves flag i unchanged.
- R3: `req_o[i]` always shows request flag i of buffer i.
- R4: In `ST_IDLE`, with init low and at least one flag set, `start_o` is high for exactly one cycle. `start_idx_o` names the lowest-numbered set flag, and the sequencer moves to `ST_WAIT`.
- R5: A done pulse with `ok_i`=1 in `ST_WAIT` clears the flag of the in-flight buffer. `req_o` shows the cleared flag in the next cycle.
- R6: A done pulse with `ok_i`=0 in `ST_WAIT` leaves the flag set. The same buffer is started again from `ST_IDLE`.
- R7: While `init_i` is high, all flags are cleared from the next cycle on. Writes are ignored and no start pulse is issued.
- R8: If init rises while a frame is in flight, the sequencer enters `ST_ABORT`. It issues no start until done arrives, and then it does not retry that frame.
- R9: `busy_o[i]` is 1 when flag i is set or when buffer i is the in-flight frame in `ST_WAIT` or `ST_ABORT`.
- R10: A write of 1 to the in-flight buffer in the same cycle as its successful done leaves that flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Controller initialization level |
| wr_en_i | input | 1 | Request write strobe |
| wr_data_i | input | NBUF | Write-one-to-set request mask |
| req_o | output | NBUF | Read-back of the request flags |
| busy_o | output | NBUF | Per-buffer data-lock flag |
| start_o | output | 1 | One-cycle transmit start toward the engine |
| start_idx_o | output | $clog2(NBUF) | Buffer index carried with the start pulse |
| done_i | input | 1 | Engine completion pulse |
| ok_i | input | 1 | Completion result: 1 success, 0 error |

## Verification
A single request tells whether the flag is set and the start index is right. A request followed by a failed and then a successful completion tells retry apart from retirement. A sparse multi-bit mask completed in turn shows lowest-first ordering. Raising init during a frame that then fails separates the abort path from normal retry. Writes during init, and a same-cycle rewrite on success, expose wrong priority between set, clear and init.

// File: rtl/txreq_pkg.sv
package txreq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_ABORT = 2'd2
    } txq_state_e;
endpackage

// File: rtl/txreq_bits.sv
module txreq_bits #(
    parameter int NBUF = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_all,
    input  logic [NBUF-1:0] set_vec,
    input  logic [NBUF-1:0] clr_vec,
    output logic [NBUF-1:0] req_q
);
    // Priority: init wipe, then set, then clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            req_q <= '0;
        else if (clr_all)
            req_q <= '0;
        else
            req_q <= (req_q & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/txreq_pick.sv
module txreq_pick #(
    parameter int NBUF = 8,
    localparam int IW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic [NBUF-1:0] req,
    output logic            any,
    output logic [IW-1:0]   idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NBUF - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/txreq_ctrl.sv
module txreq_ctrl #(
    parameter int NBUF = 8,
    localparam int IW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init_i,
    input  logic            wr_en_i,
    input  logic [NBUF-1:0] wr_data_i,
    output logic [NBUF-1:0] req_o,
    output logic [NBUF-1:0] busy_o,
    output logic            start_o,
    output logic [IW-1:0]   start_idx_o,
    input  logic            done_i,
    input  logic            ok_i
);
    import txreq_pkg::*;

    txq_state_e      st, st_nx;
    logic [IW-1:0]   cur_idx;
    logic [IW-1:0]   pick_idx;
    logic            pick_any;
    logic            retire;
    logic            in_flight;
    logic [NBUF-1:0] set_vec;
    logic [NBUF-1:0] clr_vec;

    txreq_bits #(.NBUF(NBUF)) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (init_i),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .req_q   (req_o)
    );

    txreq_pick #(.NBUF(NBUF)) u_pick (
        .req (req_o),
        .any (pick_any),
        .idx (pick_idx)
    );

    assign set_vec = (wr_en_i && !init_i) ? wr_data_i : '0;

    // State register and in-flight index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cur_idx <= '0;
        end else begin
            st <= st_nx;
            if (start_o) cur_idx <= pick_idx;
        end
    end

    // Next state and outputs
    always_comb begin
        st_nx       = st;
        start_o     = 1'b0;
        retire      = 1'b0;
        in_flight   = 1'b0;
        start_idx_o = pick_idx;
        unique case (st)
            ST_IDLE: begin
                if (pick_any && !init_i) begin
                    start_o = 1'b1;
                    st_nx   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                in_flight = 1'b1;
                if (done_i) begin
                    retire = ok_i;
                    st_nx  = ST_IDLE;
                end else if (init_i) begin
                    st_nx = ST_ABORT;
                end
            end
            ST_ABORT: begin
                in_flight = 1'b1;
                if (done_i) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    generate
        for (genvar g = 0; g < NBUF; g++) begin : g_buf
            assign clr_vec[g] = retire && (cur_idx == IW'(g));
            assign busy_o[g]  = req_o[g] || (in_flight && (cur_idx == IW'(g)));
        end
    endgenerate
endmodule

// File: rtl/txreq_ctrl_chk.sv
module txreq_ctrl_chk #(
    parameter int NBUF = 8,
    localparam int IW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  init_i,
    input logic                  wr_en_i,
    input logic [NBUF-1:0]       wr_data_i,
    input logic [NBUF-1:0]       req_o,
    input logic [NBUF-1:0]       busy_o,
    input logic                  start_o,
    input logic [IW-1:0]         start_idx_o,
    input logic                  done_i,
    input logic                  ok_i,
    input txreq_pkg::txq_state_e st,
    input logic [IW-1:0]         cur_idx
);
    import txreq_pkg::*;

    a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    a_r4_start_pending: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> req_o[start_idx_o]);

    a_r5_clear_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && done_i && ok_i && !(wr_en_i && !init_i && wr_data_i[cur_idx]))
        |=> !req_o[$past(cur_idx)]);

    a_r6_keep_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && done_i && !ok_i && !init_i && req_o[cur_idx])
        |=> req_o[$past(cur_idx)]);

    a_r7_init_wipe: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (req_o == '0));

    a_r7_no_start_init: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |-> !start_o);

    a_r8_quiet_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ABORT) |-> !start_o);

    a_r9_busy_covers_req: assert property (@(posedge clk) disable iff (!rst_n)
        ((busy_o & req_o) == req_o));
endmodule

bind txreq_ctrl txreq_ctrl_chk #(.NBUF(NBUF)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_i      (init_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .req_o       (req_o),
    .busy_o      (busy_o),
    .start_o     (start_o),
    .start_idx_o (start_idx_o),
    .done_i      (done_i),
    .ok_i        (ok_i),
    .st          (st),
    .cur_idx     (cur_idx)
);

// File: tb/txreq_ctrl_bench.sv
`timescale 1ns/1ps
module txreq_ctrl_bench;
    localparam int NBUF = 8;
    localparam int IW = $clog2(NBUF);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            init_i = 1'b0;
    logic            wr_en_i = 1'b0;
    logic [NBUF-1:0] wr_data_i = '0;
    logic [NBUF-1:0] req_o;
    logic [NBUF-1:0] busy_o;
    logic            start_o;
    logic [IW-1:0]   start_idx_o;
    logic            done_i = 1'b0;
    logic            ok_i = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    txreq_ctrl #(.NBUF(NBUF)) u_txreq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_i      (init_i),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .req_o       (req_o),
        .busy_o      (busy_o),
        .start_o     (start_o),
        .start_idx_o (start_idx_o),
        .done_i      (done_i),
        .ok_i        (ok_i)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [NBUF-1:0] v);
        @(negedge clk); wr_en_i = 1'b1; wr_data_i = v;
        @(negedge clk); wr_en_i = 1'b0; wr_data_i = '0;
        #1;
    endtask

    task automatic do_done(input logic ok);
        @(negedge clk); done_i = 1'b1; ok_i = ok;
        @(negedge clk); done_i = 1'b0; ok_i = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        check("R1 req", 32'(req_o), 0);
        check("R1 busy", 32'(busy_o), 0);
        check("R1 start", 32'(start_o), 0);
    endtask

    task automatic t_single_and_retry();
        do_write(8'h08);
        check("R2 set bit3", 32'(req_o), 32'h08);
        check("R4 start", 32'(start_o), 1);
        check("R4 idx", 32'(start_idx_o), 3);
        @(negedge clk); #1;
        check("R4 single pulse", 32'(start_o), 0);
        check("R9 busy in flight", 32'(busy_o), 32'h08);
        do_write(8'h00);
        check("R2 zero write ignored", 32'(req_o), 32'h08);
        check("R3 readback", 32'(req_o), 32'h08);
        do_done(1'b0);
        check("R6 kept on error", 32'(req_o), 32'h08);
        check("R6 retry start", 32'(start_o), 1);
        check("R6 retry idx", 32'(start_idx_o), 3);
        do_done(1'b1);
        check("R5 cleared", 32'(req_o), 0);
        check("R5 no start", 32'(start_o), 0);
        check("R9 busy idle", 32'(busy_o), 0);
    endtask

    task automatic t_priority();
        do_write(8'hA4);
        check("R4 lowest first", 32'(start_idx_o), 2);
        check("R9 busy mask", 32'(busy_o), 32'hA4);
        do_done(1'b1);
        check("R5 clear idx2", 32'(req_o), 32'hA0);
        check("R4 next idx5", 32'(start_idx_o), 5);
        check("R4 next start", 32'(start_o), 1);
        do_done(1'b1);
        check("R4 next idx7", 32'(start_idx_o), 7);
        do_done(1'b1);
        check("R5 all done", 32'(req_o), 0);
    endtask

    task automatic t_abort();
        do_write(8'h12);
        check("R4 idx1", 32'(start_idx_o), 1);
        @(negedge clk); init_i = 1'b1;
        @(negedge clk); #1;
        check("R7 wiped", 32'(req_o), 0);
        check("R7 no start", 32'(start_o), 0);
        check("R8 busy in abort", 32'(busy_o), 32'h02);
        @(negedge clk); init_i = 1'b0;
        #1;
        check("R8 no start before done", 32'(start_o), 0);
        do_done(1'b0);
        check("R8 no retry", 32'(start_o), 0);
        check("R8 req", 32'(req_o), 0);
        check("R8 busy released", 32'(busy_o), 0);
    endtask

    task automatic t_write_in_init();
        @(negedge clk); init_i = 1'b1;
        @(negedge clk); wr_en_i = 1'b1; wr_data_i = 8'hFF;
        @(negedge clk); wr_en_i = 1'b0; wr_data_i = '0;
        #1;
        check("R7 write ignored", 32'(req_o), 0);
        check("R7 start held", 32'(start_o), 0);
        @(negedge clk); init_i = 1'b0;
        @(negedge clk); #1;
        check("R7 after init", 32'(req_o), 0);
    endtask

    task automatic t_set_wins();
        do_write(8'h01);
        check("R4 idx0", 32'(start_idx_o), 0);
        @(negedge clk); done_i = 1'b1; ok_i = 1'b1; wr_en_i = 1'b1; wr_data_i = 8'h01;
        @(negedge clk); done_i = 1'b0; ok_i = 1'b0; wr_en_i = 1'b0; wr_data_i = '0;
        #1;
        check("R10 set wins", 32'(req_o), 32'h01);
        check("R10 restart", 32'(start_o), 1);
        do_done(1'b1);
        check("R5 final clear", 32'(req_o), 0);
    endtask

    initial begin
        #(4 * 20000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        #1;
        t_reset();
        t_single_and_retry();
        t_priority();
        t_abort();
        t_write_in_init();
        t_set_wins();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule